// File: doc/BRIEF.md
# Port FIFO with Eighth-Threshold Flags

This block is the buffering stage between a user port and the engine that moves words to and from external memory. One clock drives it. The storage is the same for both port directions. The `WRITE_PORT` parameter sets the direction:

- On a write port, the user pushes words and the memory engine pops them.
- On a read port, the memory engine pushes words and the user pops them.

The word at the head of the queue is always presented on both read-data outputs. A pop consumes that word.

The user side moves one word in every cycle where its select input is high. The memory side uses a single strobe and sees the current occupancy. The block has four status flags:

- `empty`: the FIFO holds nothing.
- `almost_empty`: occupancy is below one eighth of the depth.
- `almost_full`: occupancy is above seven eighths of the depth.
- `err`: a sticky error flag. It latches any push into a full FIFO or pop from an empty FIFO.

Such a rejected access is dropped, so the stored data stays intact. A `start` pulse discards all contents and clears the error flag.

Top module: `port_fifo`

## Requirements
- R1: `empty` is 1 exactly when `level` is 0.
- R2: `almost_empty` is 1 exactly when `level` is less than DEPTH/8.
- R3: `almost_full` is 1 exactly when `level` is greater than 7*DEPTH/8.
- R4: A push while `level` equals DEPTH is discarded, and `err` is 1 from the next cycle.
- R5: A pop while `level` is 0 is discarded, and `err` is 1 from the next cycle.
- R6: Once set, `err` stays 1 until a cycle with `start` high.
- R7: When `start` is high at a clock edge, the FIFO is empty and `err` is 0 after that edge. Any push or pop in the same cycle is ignored and does not set `err`.
- R8: Accepted words leave in the order they arrived. Whenever `level` is nonzero, the oldest word is on `usr_rdata` and `mem_rdata`. `level` rises by one for each accepted push and falls by one for each accepted pop. Nothing changes while select and strobe are low.
- R9: A push and a pop in the same cycle behave as follows:
  - When 0 < `level` < DEPTH, both are accepted and `level` is unchanged.
  - When `level` is DEPTH, only the pop is accepted and `err` sets.
  - When `level` is 0, only the push is accepted and `err` sets.
- R10: The push and pop sources depend on `WRITE_PORT`:
  - With `WRITE_PORT`=1, `usr_sel` pushes `usr_wdata` and `mem_stb` pops.
  - With `WRITE_PORT`=0, `mem_stb` pushes `mem_wdata` and `usr_sel` pops.
- R11: After reset, `level` is 0, `empty` and `almost_empty` are 1, and `almost_full` and `err` are 0.
- R12: DEPTH must be a power of two of at least 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Flush contents and clear error |
| usr_sel | input | 1 | User-side transfer select |
| usr_wdata | input | DATA_W | User write data (write port) |
| usr_rdata | output | DATA_W | Head word (read port) |
| mem_stb | input | 1 | Memory-side push or pop strobe |
| mem_wdata | input | DATA_W | Memory write data (read port) |
| mem_rdata | output | DATA_W | Head word (write port) |
| level | output | $clog2(DEPTH)+1 | Occupancy in words |
| empty | output | 1 | No entries |
| almost_empty | output | 1 | Below one eighth full |
| almost_full | output | 1 | Above seven eighths full |
| err | output | 1 | Sticky overflow/underflow flag |

## Verification
The two functions that can fall in the same cycle are a push and a pop. The bench provokes them together at the edges: with the FIFO full, with it empty, and during a long random stretch in between. A start pulse is also placed on a cycle that carries a push.

A behavioural queue model decides each outcome by the rule that the pop is checked against the occupancy before the edge. Two instances, one per direction, are compared against this model after every edge. The comparison covers occupancy, all flags and the head word.

// File: rtl/port_fifo.sv
module port_fifo #(
  parameter int DATA_W     = 32,
  parameter int DEPTH      = 128,
  parameter bit WRITE_PORT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              usr_sel,
  input  logic [DATA_W-1:0] usr_wdata,
  output logic [DATA_W-1:0] usr_rdata,
  input  logic              mem_stb,
  input  logic [DATA_W-1:0] mem_wdata,
  output logic [DATA_W-1:0] mem_rdata,
  output logic [$clog2(DEPTH):0] level,
  output logic              empty,
  output logic              almost_empty,
  output logic              almost_full,
  output logic              err
);
  localparam int AW    = $clog2(DEPTH);
  localparam int LVL_W = AW + 1;
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);
  localparam logic [LVL_W-1:0] AE_LIM   = LVL_W'(DEPTH / 8);
  localparam logic [LVL_W-1:0] AF_LIM   = LVL_W'((DEPTH / 8) * 7);

  initial begin
    if (DEPTH < 16 || (DEPTH & (DEPTH - 1)) != 0)
      $error("port_fifo: DEPTH must be a power of two >= 16 (R12)");
  end

  logic [DATA_W-1:0] store [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic              push, pop, push_ok, pop_ok, is_full;
  logic [DATA_W-1:0] push_data, head;

  generate
    if (WRITE_PORT) begin : g_wr
      assign push      = usr_sel;
      assign pop       = mem_stb;
      assign push_data = usr_wdata;
    end else begin : g_rd
      assign push      = mem_stb;
      assign pop       = usr_sel;
      assign push_data = mem_wdata;
    end
  endgenerate

  assign empty        = (level == '0);
  assign is_full      = (level == FULL_LVL);
  assign almost_empty = (level < AE_LIM);
  assign almost_full  = (level > AF_LIM);

  assign push_ok = push && !is_full && !start;
  assign pop_ok  = pop && !empty && !start;

  assign head      = store[rd_ptr];
  assign usr_rdata = head;
  assign mem_rdata = head;

  always_ff @(posedge clk) begin
    if (push_ok) store[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
      err    <= 1'b0;
    end else if (start) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
      err    <= 1'b0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
      if (push_ok && !pop_ok)      level <= level + 1'b1;
      else if (pop_ok && !push_ok) level <= level - 1'b1;
      if ((push && is_full) || (pop && empty)) err <= 1'b1;
    end
  end
endmodule

// File: rtl/port_fifo_checks.sv
module port_fifo_checks #(
  parameter int DEPTH      = 128,
  parameter bit WRITE_PORT = 1'b1
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  start,
  input logic                  usr_sel,
  input logic                  mem_stb,
  input logic [$clog2(DEPTH):0] level,
  input logic                  err
);
  logic psh, pp;
  assign psh = WRITE_PORT ? usr_sel : mem_stb;
  assign pp  = WRITE_PORT ? mem_stb : usr_sel;

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (level == DEPTH && psh && !pp && !start) |=> (level == DEPTH && err));

  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (level == 0 && pp && !psh && !start) |=> (level == 0 && err));

  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !start) |=> err);

  assert_start_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (level == 0 && !err));

  assert_balanced_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (psh && pp && level != 0 && level != DEPTH && !start) |=> $stable(level));

  assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!usr_sel && !mem_stb && !start) |=> ($stable(level) && $stable(err)));
endmodule

bind port_fifo port_fifo_checks #(.DEPTH(DEPTH), .WRITE_PORT(WRITE_PORT)) u_checks (
  .clk(clk), .rst_n(rst_n), .start(start), .usr_sel(usr_sel),
  .mem_stb(mem_stb), .level(level), .err(err)
);

// File: tb/port_fifo_test.sv
module port_fifo_test;
  localparam int DW = 16;
  localparam int D  = 16;
  localparam int LW = $clog2(D) + 1;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, sel = 1'b0, stb = 1'b0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] urd, mrd, r_urd, r_mrd;
  logic [LW-1:0] lvl, r_lvl;
  logic emp, ae, af, er, r_emp, r_ae, r_af, r_er;

  always #4 clk = ~clk;

  port_fifo #(.DATA_W(DW), .DEPTH(D), .WRITE_PORT(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .usr_sel(sel), .usr_wdata(din),
    .usr_rdata(urd), .mem_stb(stb), .mem_wdata('0), .mem_rdata(mrd),
    .level(lvl), .empty(emp), .almost_empty(ae), .almost_full(af), .err(er));

  port_fifo #(.DATA_W(DW), .DEPTH(D), .WRITE_PORT(1'b0)) uut_rd (
    .clk(clk), .rst_n(rst_n), .start(start), .usr_sel(stb), .usr_wdata('0),
    .usr_rdata(r_urd), .mem_stb(sel), .mem_wdata(din), .mem_rdata(r_mrd),
    .level(r_lvl), .empty(r_emp), .almost_empty(r_ae), .almost_full(r_af), .err(r_er));

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [DW-1:0] q[$];
  bit m_err = 1'b0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic compare(string tag);
    int n = q.size();
    chk({tag, " R8 level"}, 32'(lvl), 32'(n));
    chk({tag, " R1 empty"}, 32'(emp), 32'(n == 0));
    chk({tag, " R2 almost_empty"}, 32'(ae), 32'(n < D / 8));
    chk({tag, " R3 almost_full"}, 32'(af), 32'(n > (D / 8) * 7));
    chk({tag, " R6 err"}, 32'(er), 32'(m_err));
    if (n > 0) chk({tag, " R8 head"}, 32'(mrd), 32'(q[0]));
    chk({tag, " R10 rd level"}, 32'(r_lvl), 32'(n));
    chk({tag, " R10 rd empty"}, 32'(r_emp), 32'(n == 0));
    chk({tag, " R10 rd almost_full"}, 32'(r_af), 32'(n > (D / 8) * 7));
    chk({tag, " R10 rd err"}, 32'(r_er), 32'(m_err));
    if (n > 0) chk({tag, " R10 rd head"}, 32'(r_urd), 32'(q[0]));
  endtask

  task automatic step(string tag, bit st, bit s, bit b, logic [DW-1:0] d);
    @(negedge clk);
    compare(tag);
    start = st; sel = s; stb = b; din = d;
    @(posedge clk);
    #1;
    if (st) begin
      q.delete();
      m_err = 1'b0;
    end else begin
      bit f = (q.size() == D);
      bit e = (q.size() == 0);
      if (s && f) m_err = 1'b1;
      if (b && e) m_err = 1'b1;
      if (b && !e) void'(q.pop_front());
      if (s && !f) q.push_back(d);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step("R11 reset", 0, 0, 0, '0);
    for (int i = 0; i < D; i++) step("R2 R3 fill", 0, 1, 0, DW'(16'h100 + i));
    step("R4 overflow", 0, 1, 0, 16'hdead);
    step("R4 after", 0, 0, 0, '0);
    step("R9 full both", 0, 1, 1, 16'hbeef);
    step("R6 hold", 0, 0, 0, '0);
    step("R7 flush", 1, 0, 0, '0);
    for (int i = 0; i < 5; i++) step("R8 refill", 0, 1, 0, DW'(16'h200 + i));
    for (int i = 0; i < 5; i++) step("R8 drain", 0, 0, 1, '0);
    step("R5 underflow", 0, 0, 1, '0);
    step("R5 after", 0, 0, 0, '0);
    step("R9 empty both", 0, 1, 1, 16'h0777);
    step("R7 flush push", 1, 1, 0, 16'h1234);
    for (int i = 0; i < 3000; i++) begin
      bit bias = ((i / 200) % 2) == 0;
      int r = $urandom_range(0, 99);
      bit s = bias ? (r < 65) : (r < 35);
      bit b = ($urandom_range(0, 99) < 50);
      bit st = ($urandom_range(0, 199) == 0);
      step("R9 mix", st, s, b, DW'($urandom));
    end
    @(negedge clk);
    compare("R8 final");
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule